// File: doc/BRIEF.md
# Recentering Clock-Decoupling Elastic Buffer

This block decouples a serial transmit bit stream from the clock it arrives on. Bits are captured on a write clock. That clock is either a clock sent with the data or one recovered from it. The bits are replayed on a local reference clock that runs at the same frequency but whose phase wanders. A small circular store sits between the two clocks. The write pointer runs half the store ahead of the read pointer, so phase wander of a few bit periods in either direction passes with no bit lost or repeated.

The read side watches the occupancy that it sees through a synchronized copy of the write pointer. If wander pushes that occupancy to empty or to full, the read side raises a sticky fault flag. Two events recenter the read pointer: a rising edge on the recenter request, and a falling edge on the loss-of-lock input. Only the recenter request also clears the fault flag. For plesiochronous operation a bypass mode sends the captured bit straight out on the write clock, and the store is not used.

The read-side controller has three states. RS_HOLD drives zeros while the synchronized write pointer settles. RS_LOAD drives zeros and places the read pointer half the store behind the write pointer. RS_RUN reads one bit per reference clock. The transitions are:
- reset to RS_HOLD.
- RS_HOLD to RS_LOAD once the hold counter expires.
- RS_LOAD to RS_RUN after one cycle.
- RS_RUN, RS_LOAD and RS_HOLD to RS_HOLD on any recenter event. In RS_HOLD the event restarts the hold counter.

Top module: `tx_elastic_fifo`

## Requirements
- R1: While reset is asserted, and for at least four reference cycles after it is released, out_bit is 0 and fifo_err is 0.
- R2: Each bit of wr_bit is captured on the rising edge of wr_clk. With bypass_en at 0, the reference-side stream is lossless while the phase offset between the clocks stays within ±4 bit periods. Lossless means it is an unbroken, non-constant copy of the written sequence.
- R3: In RS_RUN, fifo_err is set one reference cycle after the observed occupancy reaches 0 (write clock too slow) or reaches the store depth or more (write clock too fast).
- R4: Once set, fifo_err stays at 1 until a recenter request edge. A later return of the drift inside tolerance does not clear it. A loss-of-lock recenter does not clear it either.
- R5: A falling edge of lock_lost, after its synchronizer, recenters the buffer. The observed occupancy after RS_LOAD is half the depth plus at most 2, and an unbroken stream resumes.
- R6: A rising edge of recenter_req clears fifo_err and recenters the buffer. The clear takes precedence over a limit condition detected in the same cycle.
- R7: With bypass_en at 1, out_bit equals the wr_bit value captured at the most recent rising edge of wr_clk.
- R8: With bypass_en at 0, out_bit is 0 in every cycle driven from RS_HOLD or RS_LOAD. After a lock_lost fall applied just after a reference edge, this covers at least the 4th to 8th following reference edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock (incoming or recovered serial clock) |
| rd_clk | input | 1 | Local reference read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_bit | input | 1 | Serial transmit data, sampled on the rising edge of wr_clk |
| bypass_en | input | 1 | 1 selects the plesiochronous straight-through path |
| lock_lost | input | 1 | Loss-of-lock indicator; its falling edge recenters |
| recenter_req | input | 1 | Recenter request; its rising edge clears the fault and recenters |
| out_bit | output | 1 | Serial data toward the line side |
| fifo_err | output | 1 | Sticky over/underflow flag |

## Verification
The clearing edge of recenter_req and the limit detection can act on fifo_err in the same reference cycle. The bench provokes this by keeping the write clock drifting until the buffer has been pinned at a limit for hundreds of cycles. It then raises the recenter request while the drift is still running. The result is judged at the ports: fifo_err must read 0 once recentering has finished, and the stream that follows must be unbroken.

// File: rtl/efifo_pkg.sv
package efifo_pkg;
    typedef enum logic [1:0] {
        RS_HOLD = 2'd0,
        RS_LOAD = 2'd1,
        RS_RUN  = 2'd2
    } rd_state_e;
endpackage

// File: rtl/efifo_sync.sv
module efifo_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/efifo_wr.sv
module efifo_wr #(
    parameter int AW = 4
) (
    input  logic                wr_clk,
    input  logic                rst_n,
    input  logic                wr_bit,
    output logic [AW:0]         wr_gray,
    output logic [(1<<AW)-1:0]  store,
    output logic                byp_q
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wr_bin;
    logic [PW-1:0] wr_bin_nx;

    assign wr_bin_nx = wr_bin + 1'b1;

    // Data is captured on the rising edge of the write clock (R2)
    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_bin  <= '0;
            wr_gray <= '0;
            store   <= '0;
            byp_q   <= 1'b0;
        end else begin
            store[wr_bin[AW-1:0]] <= wr_bit;
            wr_bin  <= wr_bin_nx;
            wr_gray <= wr_bin_nx ^ (wr_bin_nx >> 1);
            byp_q   <= wr_bit;
        end
    end
endmodule

// File: rtl/efifo_rd.sv
module efifo_rd
    import efifo_pkg::*;
#(
    parameter int AW       = 4,
    parameter int HOLD_CYC = 6
) (
    input  logic               rd_clk,
    input  logic               rst_n,
    input  logic [AW:0]        wr_gray_s,
    input  logic [(1<<AW)-1:0] store,
    input  logic               lock_s,
    input  logic               clr_s,
    output rd_state_e          state_q,
    output logic [AW:0]        occ,
    output logic               clr_evt,
    output logic               fifo_out,
    output logic               fifo_err
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;
    localparam int HALF  = DEPTH / 2;
    localparam int CW    = $clog2(HOLD_CYC + 1);

    rd_state_e     state_d;
    logic [CW-1:0] hold_cnt;
    logic [PW-1:0] wr_bin_s;
    logic [PW-1:0] rd_bin;
    logic          lock_d, clr_d;
    logic          lock_fall, recenter_evt, at_limit;

    // Gray to binary for the synchronized write pointer
    always_comb begin
        for (int i = 0; i < PW; i++) wr_bin_s[i] = ^(wr_gray_s >> i);
    end

    assign lock_fall    = lock_d & ~lock_s;
    assign clr_evt      = clr_s & ~clr_d;
    assign recenter_evt = lock_fall | clr_evt;
    assign occ          = wr_bin_s - rd_bin;
    assign at_limit     = (occ == '0) || (occ >= PW'(DEPTH));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_HOLD: state_d = (!recenter_evt && hold_cnt == CW'(HOLD_CYC - 1)) ? RS_LOAD : RS_HOLD;
            RS_LOAD: state_d = recenter_evt ? RS_HOLD : RS_RUN;
            RS_RUN:  state_d = recenter_evt ? RS_HOLD : RS_RUN;
            default: state_d = RS_HOLD;
        endcase
    end

    // State register, hold counter, read pointer, edge history
    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= RS_HOLD;
            hold_cnt <= '0;
            rd_bin   <= '0;
            lock_d   <= 1'b0;
            clr_d    <= 1'b0;
        end else begin
            state_q  <= state_d;
            hold_cnt <= (state_q == RS_HOLD && !recenter_evt) ? hold_cnt + 1'b1 : '0;
            lock_d   <= lock_s;
            clr_d    <= clr_s;
            unique case (state_q)
                RS_LOAD: rd_bin <= wr_bin_s - PW'(HALF);
                RS_RUN:  rd_bin <= rd_bin + 1'b1;
                default: rd_bin <= rd_bin;
            endcase
        end
    end

    // Outputs: data only in RS_RUN, sticky fault with clear priority
    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_out <= 1'b0;
            fifo_err <= 1'b0;
        end else begin
            fifo_out <= (state_q == RS_RUN) ? store[rd_bin[AW-1:0]] : 1'b0;
            if (clr_evt)
                fifo_err <= 1'b0;
            else if (state_q == RS_RUN && at_limit)
                fifo_err <= 1'b1;
        end
    end
endmodule

// File: rtl/tx_elastic_fifo.sv
module tx_elastic_fifo
    import efifo_pkg::*;
#(
    parameter int AW          = 4,
    parameter int HOLD_CYC    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic wr_clk,
    input  logic rd_clk,
    input  logic rst_n,
    input  logic wr_bit,
    input  logic bypass_en,
    input  logic lock_lost,
    input  logic recenter_req,
    output logic out_bit,
    output logic fifo_err
);
    localparam int DEPTH = 1 << AW;

    logic [AW:0]      wr_gray, wr_gray_s;
    logic [DEPTH-1:0] store;
    logic             byp_q, fifo_out, clr_evt;
    logic [1:0]       ctl_s;
    logic [AW:0]      rd_occ;
    rd_state_e        rd_state;

    efifo_wr #(.AW(AW)) u_wr (
        .wr_clk (wr_clk),
        .rst_n  (rst_n),
        .wr_bit (wr_bit),
        .wr_gray(wr_gray),
        .store  (store),
        .byp_q  (byp_q)
    );

    efifo_sync #(.W(AW + 1), .STAGES(SYNC_STAGES)) u_ptr_sync (
        .clk  (rd_clk),
        .rst_n(rst_n),
        .d    (wr_gray),
        .q    (wr_gray_s)
    );

    efifo_sync #(.W(2), .STAGES(SYNC_STAGES)) u_ctl_sync (
        .clk  (rd_clk),
        .rst_n(rst_n),
        .d    ({lock_lost, recenter_req}),
        .q    (ctl_s)
    );

    efifo_rd #(.AW(AW), .HOLD_CYC(HOLD_CYC)) u_rd (
        .rd_clk   (rd_clk),
        .rst_n    (rst_n),
        .wr_gray_s(wr_gray_s),
        .store    (store),
        .lock_s   (ctl_s[1]),
        .clr_s    (ctl_s[0]),
        .state_q  (rd_state),
        .occ      (rd_occ),
        .clr_evt  (clr_evt),
        .fifo_out (fifo_out),
        .fifo_err (fifo_err)
    );

    assign out_bit = bypass_en ? byp_q : fifo_out;
endmodule

// File: rtl/efifo_checker.sv
module efifo_checker
    import efifo_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic       rd_clk,
    input  logic       rst_n,
    input  rd_state_e  rd_state,
    input  logic [AW:0] rd_occ,
    input  logic       clr_evt,
    input  logic       fifo_out,
    input  logic       fifo_err
);
    localparam int DEPTH = 1 << AW;
    localparam int HALF  = DEPTH / 2;

    assert_err_detect_R3: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_state == RS_RUN && !clr_evt && (rd_occ == 0 || rd_occ >= DEPTH)) |=> fifo_err);

    assert_err_sticky_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $fell(fifo_err) |-> $past(clr_evt));

    assert_load_center_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_state == RS_LOAD) |=> (rd_occ >= HALF && rd_occ <= HALF + 2));

    assert_clear_wins_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
        clr_evt |=> !fifo_err);

    assert_hold_zero_R8: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_state != RS_RUN) |=> !fifo_out);
endmodule

bind tx_elastic_fifo efifo_checker #(.AW(AW)) u_chk (
    .rd_clk  (rd_clk),
    .rst_n   (rst_n),
    .rd_state(rd_state),
    .rd_occ  (rd_occ),
    .clr_evt (clr_evt),
    .fifo_out(fifo_out),
    .fifo_err(fifo_err)
);

// File: tb/tx_elastic_fifo_test.sv
`timescale 1ns/1ps
module tx_elastic_fifo_test;
    logic wr_clk, rd_clk, rst_n, wr_bit, bypass_en, lock_lost, recenter_req;
    logic out_bit, fifo_err;
    real  wr_adj = 0.0;

    int checks = 0, failures = 0;
    bit chk_on = 0, byp_chk = 0;
    int mism = 0, ones = 0, nhist = 0, byp_bad = 0, byp_n = 0;
    logic [6:0] hist = '0;
    logic [6:0] prbs = 7'h5A;

    tx_elastic_fifo uut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_bit(wr_bit),
        .bypass_en(bypass_en), .lock_lost(lock_lost), .recenter_req(recenter_req),
        .out_bit(out_bit), .fifo_err(fifo_err)
    );

    // 50 MHz reference
    initial begin
        rd_clk = 0;
        forever #10 rd_clk = ~rd_clk;
    end

    // Write clock with a programmable per-cycle phase slip
    initial begin
        wr_clk = 0;
        forever begin
            #10 wr_clk = 1;
            #(10.0 + wr_adj) wr_clk = 0;
        end
    end

    // Write data source (PRBS7) and bypass comparison
    initial begin
        wr_bit = 0;
        forever begin
            @(negedge wr_clk);
            if (byp_chk) begin
                byp_n++;
                if (out_bit !== wr_bit) byp_bad++;
            end
            prbs   = {prbs[5:0], prbs[6] ^ prbs[5]};
            wr_bit = prbs[0];
        end
    end

    // Stream continuity checker on the reference side
    initial begin
        forever begin
            @(negedge rd_clk);
            if (chk_on) begin
                if (nhist >= 7) begin
                    if (out_bit !== (hist[6] ^ hist[5])) mism++;
                end else nhist++;
                hist = {hist[5:0], out_bit};
                if (out_bit) ones++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_rd(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    task automatic stream_window(input int n, input string req);
        mism = 0; ones = 0; nhist = 0;
        chk_on = 1;
        wait_rd(n);
        chk_on = 0;
        check(mism == 0, req, "stream breaks", mism, 0);
        check(ones > 0, req, "stream ones", ones, 1);
    endtask

    task automatic t_reset;
        int zb = 0;
        rst_n = 0; bypass_en = 0; lock_lost = 0; recenter_req = 0;
        wait_rd(5);
        check(out_bit == 0, "R1", "out in reset", out_bit, 0);
        check(fifo_err == 0, "R1", "err in reset", fifo_err, 0);
        rst_n = 1;
        for (int k = 0; k < 4; k++) begin
            @(negedge rd_clk);
            if (out_bit !== 1'b0 || fifo_err !== 1'b0) zb++;
        end
        check(zb == 0, "R1", "quiet after reset", zb, 0);
        wait_rd(30);
    endtask

    task automatic t_tolerance;
        mism = 0; ones = 0; nhist = 0;
        chk_on = 1;
        wr_adj =  0.5; wait_rd(120);
        wr_adj = -0.5; wait_rd(240);
        wr_adj =  0.5; wait_rd(120);
        wr_adj =  0.0; wait_rd(40);
        chk_on = 0;
        check(mism == 0, "R2", "breaks under wander", mism, 0);
        check(ones > 0, "R2", "ones under wander", ones, 1);
        check(fifo_err == 0, "R2", "err under wander", fifo_err, 0);
    endtask

    task automatic t_underflow_then_clear;
        wr_adj = 1.0;
        wait_rd(400);
        check(fifo_err == 1, "R3", "err after underflow drift", fifo_err, 1);
        // clear pulse while still pinned at a limit
        recenter_req = 1; wait_rd(4);
        recenter_req = 0; wait_rd(26);
        check(fifo_err == 0, "R6", "clear wins over limit", fifo_err, 0);
        wr_adj = 0.0;
        wait_rd(20);
        stream_window(200, "R6");
    endtask

    task automatic t_overflow_sticky;
        wr_adj = -1.0;
        wait_rd(300);
        check(fifo_err == 1, "R3", "err after overflow drift", fifo_err, 1);
        wr_adj = 0.0;
        wait_rd(100);
        check(fifo_err == 1, "R4", "err held after drift stops", fifo_err, 1);
    endtask

    task automatic t_lock_recenter;
        int zb = 0;
        lock_lost = 1; wait_rd(10);
        lock_lost = 0;
        for (int k = 1; k <= 12; k++) begin
            @(negedge rd_clk);
            if (k >= 4 && k <= 8 && out_bit !== 1'b0) zb++;
        end
        check(zb == 0, "R8", "zeros while recentering", zb, 0);
        wait_rd(20);
        check(fifo_err == 1, "R4", "err kept over lock recenter", fifo_err, 1);
        stream_window(200, "R5");
    endtask

    task automatic t_clear;
        recenter_req = 1; wait_rd(4);
        recenter_req = 0; wait_rd(30);
        check(fifo_err == 0, "R6", "err cleared by request", fifo_err, 0);
        stream_window(100, "R6");
    endtask

    task automatic t_bypass;
        bypass_en = 1;
        @(negedge wr_clk); @(negedge wr_clk);
        byp_bad = 0; byp_n = 0; byp_chk = 1;
        wait_rd(100);
        byp_chk = 0;
        check(byp_bad == 0 && byp_n > 50, "R7", "bypass mismatches", byp_bad, 0);
        bypass_en = 0;
    endtask

    initial begin
        #4000000;
        checks++; failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_tolerance();
        t_underflow_then_clear();
        t_overflow_sticky();
        t_lock_recenter();
        t_clear();
        t_bypass();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule